// File: doc/BRIEF.md
# Handshake Pulse Synchronizer

This block carries single-cycle event pulses from one clock domain into a second, unrelated clock domain. It reports back to the sender when each event has been delivered. On the sending side, every accepted pulse inverts a level register. That level stays put until the receiving side has seen it, so it is captured correctly even when the receiving clock is much slower than the sending clock. In the receiving domain, a chain of flip-flops resolves metastability on the level. An edge detector then turns each level change, rising or falling, into a pulse one destination cycle wide.

The level the receiver has consumed travels back to the sender through a second flip-flop chain. While that returned level differs from the sender's own level, the sender reports itself busy. A pulse offered while busy is dropped, and the busy output lets the surrounding logic see that. It can then hold the event and present it again once busy clears. Neither clock is assumed faster than the other.

Top module: `pulse_handshake_sync`

## Requirements
- R1: Every accepted source pulse produces exactly one `dst_pulse_o`, high for exactly one destination cycle. No destination pulse appears without an accepted source pulse. A source pulse is accepted when `src_pulse_i` is 1 on a source edge while `src_busy_o` is 0.
- R2: `src_busy_o` is 1 during the source cycle that directly follows the edge accepting a pulse. It never rises except after such an edge.
- R3: A `src_pulse_i` sampled while `src_busy_o` is 1 has no effect. It produces no destination pulse and does not change the timing of `src_busy_o`.
- R4: `dst_pulse_o` is high during the destination cycle that follows the SYNC_STAGES-th destination rising edge after the source edge that accepted the pulse.
- R5: One destination edge after the pulse is consumed, the returned level changes. `src_busy_o` falls after the SYNC_STAGES-th source rising edge following that change.
- R6: While either reset is low, all registers in that domain are 0. After release, `src_busy_o` and `dst_pulse_o` stay 0 until a pulse is accepted.
- R7: The block behaves as in R1 to R5 both with a source clock faster than the destination clock and with a source clock slower than it.
- R8: A pulse offered on the first source cycle in which `src_busy_o` is 0 again is accepted. This allows one transfer per full handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_pulse_i | input | 1 | Event request, one source cycle wide |
| src_busy_o | output | 1 | High while a transfer awaits acknowledge |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_pulse_o | output | 1 | Delivered event, one destination cycle wide |

## Verification
The embedded properties check the following on every cycle: busy rises after each accepted request and only then, a request made while busy leaves the source level untouched, and a destination pulse never lasts two cycles. Exact delivery latency in each domain, the timing of busy release, and the match between accepted and delivered events across long runs depend on how the two clocks interleave. Only the bench's reference model shows these, under both frequency orderings and under single, continuous, periodic and pseudo-random request patterns.

// File: rtl/pulse_hs_pkg.sv
package pulse_hs_pkg;
  localparam int MIN_SYNC_STAGES = 2;

  function automatic int safe_stages(int req);
    return (req < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : req;
  endfunction
endpackage

// File: rtl/phs_sync_chain.sv
module phs_sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/phs_src_ctrl.sv
module phs_src_ctrl #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic ack_lvl_i,
  output logic tgl_o,
  output logic busy_o
);
  logic tgl_q;
  logic ack_s;
  logic accept;

  // returned level from destination domain
  phs_sync_chain #(.WIDTH(1), .STAGES(STAGES)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ack_lvl_i),
    .q_o    (ack_s)
  );

  assign busy_o = tgl_q ^ ack_s;
  assign accept = pulse_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= tgl_q ^ accept;
  end

  assign tgl_o = tgl_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && !busy_o) |=> busy_o); // R2
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pulse_i)); // R2
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && busy_o) |=> $stable(tgl_o)); // R3
endmodule

// File: rtl/phs_dst_ctrl.sv
module phs_dst_ctrl #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_lvl_i,
  output logic pulse_o,
  output logic ack_lvl_o
);
  logic tgl_s;
  logic seen_q;

  phs_sync_chain #(.WIDTH(1), .STAGES(STAGES)) u_tgl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_lvl_i),
    .q_o    (tgl_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= tgl_s;
  end

  // either edge of the synchronized level is one event
  assign pulse_o   = tgl_s ^ seen_q;
  assign ack_lvl_o = seen_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R1
endmodule

// File: rtl/pulse_handshake_sync.sv
module pulse_handshake_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic src_pulse_i,
  output logic src_busy_o,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic dst_pulse_o
);
  localparam int Stages = pulse_hs_pkg::safe_stages(SYNC_STAGES);

  logic tgl_lvl;
  logic ack_lvl;

  phs_src_ctrl #(.STAGES(Stages)) u_src (
    .clk_i     (src_clk_i),
    .rst_ni    (src_rst_ni),
    .pulse_i   (src_pulse_i),
    .ack_lvl_i (ack_lvl),
    .tgl_o     (tgl_lvl),
    .busy_o    (src_busy_o)
  );

  phs_dst_ctrl #(.STAGES(Stages)) u_dst (
    .clk_i     (dst_clk_i),
    .rst_ni    (dst_rst_ni),
    .tgl_lvl_i (tgl_lvl),
    .pulse_o   (dst_pulse_o),
    .ack_lvl_o (ack_lvl)
  );
endmodule

// File: tb/tb_pulse_handshake_sync.sv
`timescale 1ns/100ps
module tb_pulse_handshake_sync;
  localparam int STG = 2;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic src_pulse = 1'b0;
  logic src_busy, dst_pulse;

  pulse_handshake_sync #(.SYNC_STAGES(STG)) dut (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .src_pulse_i(src_pulse),
    .src_busy_o(src_busy), .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .dst_pulse_o(dst_pulse)
  );

  // 0.5 ns ticks; even half periods keep source edges on even ticks and
  // destination edges on odd ticks, so no two edges ever coincide
  int src_half = 10, dst_half = 34, src_half_nx = 10, dst_half_nx = 34;
  int sc = 0, dc = 1;
  initial forever begin
    #0.5;
    sc++; dc++;
    if (sc >= src_half) begin src_clk = ~src_clk; sc = 0; src_half = src_half_nx; end
    if (dc >= dst_half) begin dst_clk = ~dst_clk; dc = 0; dst_half = dst_half_nx; end
  end

  int n_cmp = 0, n_bad = 0;
  int n_acc = 0, n_ign = 0, n_pres = 0, n_dst = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: sampled-level queues, oldest entry at the back
  bit m_tgl = 0, m_dprev = 0;
  bit ackq[$];
  bit dq[$];
  initial for (int i = 0; i < STG; i++) begin ackq.push_back(1'b0); dq.push_back(1'b0); end

  always @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      m_tgl = 0;
      for (int i = 0; i < STG; i++) ackq[i] = 1'b0;
    end else begin
      bit acc;
      acc = src_pulse && !(m_tgl ^ ackq[STG-1]);
      if (src_pulse) n_pres++;
      if (acc) n_acc++;
      else if (src_pulse) n_ign++;
      m_tgl ^= acc;
      void'(ackq.pop_back());
      ackq.push_front(m_dprev);
    end
  end

  always @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      m_dprev = 0;
      for (int i = 0; i < STG; i++) dq[i] = 1'b0;
    end else begin
      m_dprev = dq[STG-1];
      void'(dq.pop_back());
      dq.push_front(m_tgl);
    end
  end

  always @(negedge src_clk) if (!done) begin
    bit eb;
    eb = m_tgl ^ ackq[STG-1];
    chk(src_busy === eb, "R2 R5 R8 busy", int'(src_busy), int'(eb));
  end

  always @(negedge dst_clk) if (!done) begin
    bit ep;
    ep = dq[STG-1] ^ m_dprev;
    chk(dst_pulse === ep, "R1 R4 dst pulse", int'(dst_pulse), int'(ep));
    if (dst_pulse === 1'b1) n_dst++;
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic drive(int mode, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge src_clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: src_pulse = (i == 0);
        1: src_pulse = 1'b1;
        2: src_pulse = lfsr[0] & lfsr[3];
        default: src_pulse = (i % 3 == 0);
      endcase
    end
    @(negedge src_clk);
    src_pulse = 1'b0;
  endtask

  task automatic run_phase(int sh, int dh, string tag);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_half_nx = sh;
    dst_half_nx = dh;
    repeat (6) @(negedge dst_clk);
    repeat (6) @(negedge src_clk);
    chk(src_busy === 1'b0, {"R6 busy in reset ", tag}, int'(src_busy), 0);
    chk(dst_pulse === 1'b0, {"R6 pulse in reset ", tag}, int'(dst_pulse), 0);
    @(negedge src_clk); src_rst_n = 1'b1;
    @(negedge dst_clk); dst_rst_n = 1'b1;
    n_acc = 0; n_ign = 0; n_pres = 0; n_dst = 0;
    repeat (30) @(negedge dst_clk);
    chk(n_dst == 0, {"R6 quiet after release ", tag}, n_dst, 0);
    drive(0, 1);
    repeat (40) @(negedge src_clk);
    chk(n_dst == 1, {"R1 single event ", tag}, n_dst, 1);
    drive(1, 300);
    drive(3, 300);
    drive(2, 600);
    repeat (80) @(negedge src_clk);
    chk(n_dst == n_acc, {"R1 R7 delivered count ", tag}, n_dst, n_acc);
    chk(n_ign > 0 && n_acc < n_pres, {"R3 requests dropped while busy ", tag}, n_acc, n_pres);
    chk(src_busy === 1'b0, {"R5 idle after drain ", tag}, int'(src_busy), 0);
  endtask

  initial begin
    run_phase(10, 34, "fast-to-slow");
    run_phase(34, 10, "slow-to-fast");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule